// File: doc/BRIEF.md
# Bus Error Capture and Locking

This block sits beside a bus slave and records the errors that its transfers run into. Four kinds of error are recognised: an access that breaks a bank's permission (protect), an error signalled by the external device, a device-paced timeout, and a read parity mismatch. The first two are always recognised. The other two count only while their enable bits in a small configuration register are set. Any error that counts sends a one-cycle response pulse to the master that issued the transfer. A protect violation also stops the external bus cycle from starting.

Two masters each have a status field: four error-kind bits, a field lock and an address lock. One 32-bit error-address register is shared by both. An error that asks for locking freezes the field of the master that issued it. The same error also takes the address lock if no master holds it yet. While the address lock is held, no error updates the address. Software reads the fields, the address and the configuration through a simple register port, and clears status bits by writing ones.

Each master's field is run by a state machine with three states. ST_EMPTY means nothing is logged. ST_OPEN means an error is logged but not locked. ST_LOCKED means the field is frozen. The transitions are `log` (EMPTY/OPEN to OPEN), `log_lock` (EMPTY/OPEN to LOCKED), and `clear`, which goes back to OPEN or EMPTY depending on which bits remain. The shared address has a second machine with the states AD_FREE and AD_HELD. `grab` moves it from AD_FREE to AD_HELD when a locking error is logged. `release` moves it back when software clears the owner's address-lock bit.

Top module: `berr_capture`

## Requirements
- R1: After reset, both status fields, the error address and the configuration read as zero. Register select 0 and 1 are the status fields of master 0 and master 1, select 2 is the error address, and select 3 is the configuration.
- R2: The status field layout is: bit0 protect, bit1 external error, bit2 timeout, bit3 parity, bit4 field lock, bit5 address lock. Protect and external errors are always recorded.
- R3: Configuration bit0 enables timeout errors and bit1 enables parity errors. A disabled kind gives no response and is not recorded.
- R4: `bus_start` follows `xfer_start`, except that it stays low in any cycle where `ev_protect` is high.
- R5: In the cycle of `xfer_done`, `err_resp` has only the bit of the issuing master set, and only if at least one enabled error is present.
- R6: An error logged without a lock request, into a field that is not locked, replaces that field's kind bits.
- R7: An error logged with a lock request sets the field lock (bit4). While that bit is set, later errors leave the master's kind bits unchanged.
- R8: A locking error captures the address and sets that master's address-lock bit (bit5), but only if no master already holds the address lock.
- R9: While any address lock is held, the error address does not change.
- R10: While no address lock is held, every logged error writes its address, whether or not the issuing master's field is locked.
- R11: A write to a status field clears, in one cycle, every bit written as one. Clearing bit5 releases the address lock; the captured address is kept.
- R12: If an error from a master arrives in the same cycle as a write to that master's status field, the write wins and the error is not logged (neither field nor address). The response still pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xfer_start | input | 1 | Request to start an external bus cycle |
| bus_start | output | 1 | External bus cycle start, blocked on protect |
| xfer_done | input | 1 | Transfer completes; error strobes are valid |
| xfer_master | input | 1 | ID of the issuing master |
| xfer_lock | input | 1 | Master requests error locking |
| xfer_addr | input | 32 | Transfer address |
| ev_protect | input | 1 | Bank permission violation |
| ev_ext | input | 1 | External device error |
| ev_timeout | input | 1 | Device-paced timeout |
| ev_parity | input | 1 | Read parity mismatch |
| err_resp | output | 2 | Error response, one bit per master |
| sw_wr | input | 1 | Register write strobe |
| sw_sel | input | 2 | Register select |
| sw_wdata | input | 6 | Write data (ones clear status bits; bits 1:0 set configuration) |
| sw_rdata | output | 32 | Read data for the selected register |

## Verification
`bus_start` and `err_resp` are combinational, so each is due in the same cycle as its stimulus. The bench drives inputs just after a falling edge and samples these outputs a nanosecond later, before the next rising edge. A logged error, a clear or a configuration write shows up in `sw_rdata` one rising edge later. Register reads therefore go into a scoreboard queue only after the write or transfer has finished. The monitor compares each read shortly after the rising edge that follows the select change, while the select is still held.

// File: rtl/berr_pkg.sv
package berr_pkg;
    localparam int KIND_W   = 4;
    localparam int FLD_W    = 6;
    localparam int B_FLOCK  = 4;
    localparam int B_ALOCK  = 5;

    typedef enum logic [1:0] {
        ST_EMPTY  = 2'd0,
        ST_OPEN   = 2'd1,
        ST_LOCKED = 2'd2
    } fld_state_t;

    typedef enum logic {
        AD_FREE = 1'b0,
        AD_HELD = 1'b1
    } adr_state_t;
endpackage

// File: rtl/berr_classify.sv
module berr_classify
    import berr_pkg::*;
#(
    parameter int NM    = 2,
    parameter int MID_W = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xfer_start,
    input  logic              xfer_done,
    input  logic [MID_W-1:0]  xfer_master,
    input  logic              ev_protect,
    input  logic              ev_ext,
    input  logic              ev_timeout,
    input  logic              ev_parity,
    input  logic              tmo_en,
    input  logic              par_en,
    output logic [KIND_W-1:0] kinds,
    output logic              err_any,
    output logic [NM-1:0]     err_resp,
    output logic              bus_start
);
    always_comb begin
        kinds   = {ev_parity & par_en, ev_timeout & tmo_en, ev_ext, ev_protect};
        err_any = xfer_done & (|kinds);
    end

    assign bus_start = xfer_start & ~ev_protect;

    for (genvar i = 0; i < NM; i++) begin : g_resp
        assign err_resp[i] = err_any & (xfer_master == MID_W'(i));
    end

    // R4: protect must keep the external bus quiet
    a_r4_protect_no_bus: assert property (@(posedge clk) disable iff (!rst_n)
        ev_protect |-> !bus_start);
    // R5: at most one master gets a response
    a_r5_resp_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(err_resp));
    // R5: no response outside a completed transfer
    a_r5_resp_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_done |-> (err_resp == '0));
endmodule

// File: rtl/berr_field_fsm.sv
module berr_field_fsm
    import berr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic [B_FLOCK:0]  clr_bits,
    input  logic              log_en,
    input  logic              lock_req,
    input  logic [KIND_W-1:0] log_kinds,
    output logic [KIND_W-1:0] kinds,
    output logic              flock
);
    fld_state_t state, nxt_state;
    logic [KIND_W-1:0] nxt_kinds;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_EMPTY;
            kinds <= '0;
        end else begin
            state <= nxt_state;
            kinds <= nxt_kinds;
        end
    end

    always_comb begin
        nxt_state = state;
        nxt_kinds = kinds;
        if (clr) begin
            nxt_kinds = kinds & ~clr_bits[KIND_W-1:0];
            if (state == ST_LOCKED && !clr_bits[B_FLOCK])
                nxt_state = ST_LOCKED;
            else if (|nxt_kinds)
                nxt_state = ST_OPEN;
            else
                nxt_state = ST_EMPTY;
        end else begin
            unique case (state)
                ST_EMPTY, ST_OPEN: begin
                    if (log_en) begin
                        nxt_kinds = log_kinds;
                        nxt_state = lock_req ? ST_LOCKED : ST_OPEN;
                    end
                end
                ST_LOCKED: begin
                    nxt_state = ST_LOCKED;
                end
                default: begin
                    nxt_state = ST_EMPTY;
                    nxt_kinds = '0;
                end
            endcase
        end
    end

    assign flock = (state == ST_LOCKED);

    // R7: a locked field keeps its kinds until software writes it
    a_r7_locked_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (flock && !clr) |=> $stable(kinds));
    // R12: a clear of the field lock wins over a same-cycle locking error
    a_r12_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && clr_bits[B_FLOCK]) |=> !flock);
endmodule

// File: rtl/berr_addr_lock.sv
module berr_addr_lock
    import berr_pkg::*;
#(
    parameter int NM     = 2,
    parameter int MID_W  = 1,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              log_en,
    input  logic              lock_req,
    input  logic [MID_W-1:0]  mid,
    input  logic [ADDR_W-1:0] addr,
    input  logic [NM-1:0]     clr_vec,
    input  logic              rel_bit,
    output logic [ADDR_W-1:0] bear,
    output logic              held,
    output logic [MID_W-1:0]  owner
);
    adr_state_t state, nxt_state;
    logic [ADDR_W-1:0] nxt_bear;
    logic [MID_W-1:0]  nxt_owner;
    logic              release_req;

    assign release_req = clr_vec[owner] & rel_bit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= AD_FREE;
            bear  <= '0;
            owner <= '0;
        end else begin
            state <= nxt_state;
            bear  <= nxt_bear;
            owner <= nxt_owner;
        end
    end

    always_comb begin
        nxt_state = state;
        nxt_bear  = bear;
        nxt_owner = owner;
        unique case (state)
            AD_FREE: begin
                if (log_en) begin
                    nxt_bear = addr;
                    if (lock_req) begin
                        nxt_state = AD_HELD;
                        nxt_owner = mid;
                    end
                end
            end
            AD_HELD: begin
                if (release_req)
                    nxt_state = AD_FREE;
            end
            default: nxt_state = AD_FREE;
        endcase
    end

    assign held = (state == AD_HELD);

    // R9: a held address never moves until the owner releases it
    a_r9_bear_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (held && !release_req) |=> $stable(bear));
    // R8: a locking error on a free address grants the lock to its master
    a_r8_grant_owner: assert property (@(posedge clk) disable iff (!rst_n)
        (!held && log_en && lock_req) |=> (held && owner == $past(mid)));
endmodule

// File: rtl/berr_capture.sv
module berr_capture
    import berr_pkg::*;
#(
    parameter int NM     = 2,
    parameter int ADDR_W = 32,
    localparam int MID_W = (NM > 1) ? $clog2(NM) : 1,
    localparam int SEL_W = $clog2(NM + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xfer_start,
    output logic              bus_start,
    input  logic              xfer_done,
    input  logic [MID_W-1:0]  xfer_master,
    input  logic              xfer_lock,
    input  logic [ADDR_W-1:0] xfer_addr,
    input  logic              ev_protect,
    input  logic              ev_ext,
    input  logic              ev_timeout,
    input  logic              ev_parity,
    output logic [NM-1:0]     err_resp,
    input  logic              sw_wr,
    input  logic [SEL_W-1:0]  sw_sel,
    input  logic [FLD_W-1:0]  sw_wdata,
    output logic [ADDR_W-1:0] sw_rdata
);
    logic [1:0]        cfg_q;
    logic [KIND_W-1:0] kinds;
    logic              err_any;
    logic [NM-1:0]     clr_vec;
    logic              log_ok;
    logic [NM-1:0]     log_vec;
    logic [KIND_W-1:0] fld_kinds [NM];
    logic [NM-1:0]     fld_lock;
    logic [NM-1:0]     adr_lock;
    logic [ADDR_W-1:0] bear;
    logic              adr_held;
    logic [MID_W-1:0]  adr_owner;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cfg_q <= '0;
        else if (sw_wr && sw_sel == SEL_W'(NM + 1))
            cfg_q <= sw_wdata[1:0];
    end

    berr_classify #(.NM(NM), .MID_W(MID_W)) u_cls (
        .clk        (clk),
        .rst_n      (rst_n),
        .xfer_start (xfer_start),
        .xfer_done  (xfer_done),
        .xfer_master(xfer_master),
        .ev_protect (ev_protect),
        .ev_ext     (ev_ext),
        .ev_timeout (ev_timeout),
        .ev_parity  (ev_parity),
        .tmo_en     (cfg_q[0]),
        .par_en     (cfg_q[1]),
        .kinds      (kinds),
        .err_any    (err_any),
        .err_resp   (err_resp),
        .bus_start  (bus_start)
    );

    assign log_ok = err_any & ~clr_vec[xfer_master];

    for (genvar i = 0; i < NM; i++) begin : g_fld
        assign clr_vec[i]  = sw_wr && (sw_sel == SEL_W'(i));
        assign log_vec[i]  = log_ok && (xfer_master == MID_W'(i));
        assign adr_lock[i] = adr_held && (adr_owner == MID_W'(i));

        berr_field_fsm u_fld (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr      (clr_vec[i]),
            .clr_bits (sw_wdata[B_FLOCK:0]),
            .log_en   (log_vec[i]),
            .lock_req (xfer_lock),
            .log_kinds(kinds),
            .kinds    (fld_kinds[i]),
            .flock    (fld_lock[i])
        );
    end

    berr_addr_lock #(.NM(NM), .MID_W(MID_W), .ADDR_W(ADDR_W)) u_adr (
        .clk     (clk),
        .rst_n   (rst_n),
        .log_en  (log_ok),
        .lock_req(xfer_lock),
        .mid     (xfer_master),
        .addr    (xfer_addr),
        .clr_vec (clr_vec),
        .rel_bit (sw_wdata[B_ALOCK]),
        .bear    (bear),
        .held    (adr_held),
        .owner   (adr_owner)
    );

    always_comb begin
        sw_rdata = '0;
        for (int i = 0; i < NM; i++) begin
            if (sw_sel == SEL_W'(i))
                sw_rdata = ADDR_W'({adr_lock[i], fld_lock[i], fld_kinds[i]});
        end
        if (sw_sel == SEL_W'(NM))
            sw_rdata = bear;
        else if (sw_sel == SEL_W'(NM + 1))
            sw_rdata = ADDR_W'(cfg_q);
    end

    // R8: the address lock belongs to at most one master
    a_r8_single_owner: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(adr_lock));
    // R3: disabled timeout/parity kinds never reach a field
    a_r3_disabled_not_logged: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_done && !ev_protect && !ev_ext && (ev_timeout ? !cfg_q[0] : 1'b1)
         && (ev_parity ? !cfg_q[1] : 1'b1)) |-> (err_resp == '0));
endmodule

// File: tb/sim_berr_capture.sv
`timescale 1ns/1ps
module sim_berr_capture;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xfer_start = 1'b0;
    logic        bus_start;
    logic        xfer_done = 1'b0;
    logic [0:0]  xfer_master = '0;
    logic        xfer_lock = 1'b0;
    logic [31:0] xfer_addr = '0;
    logic        ev_protect = 1'b0, ev_ext = 1'b0, ev_timeout = 1'b0, ev_parity = 1'b0;
    logic [1:0]  err_resp;
    logic        sw_wr = 1'b0;
    logic [1:0]  sw_sel = '0;
    logic [5:0]  sw_wdata = '0;
    logic [31:0] sw_rdata;

    int n_chk = 0;
    int n_bad = 0;
    bit done_flag = 1'b0;

    logic [31:0] q_exp [$];
    string       q_tag [$];

    always #2 clk = ~clk;

    berr_capture u0 (.*);

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: compares queued register reads after the rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q_exp.size() > 0) begin
                logic [31:0] e;
                string t;
                e = q_exp.pop_front();
                t = q_tag.pop_front();
                check(sw_rdata === e, t, sw_rdata, e);
            end
        end
    end

    task automatic rd(input logic [1:0] sel, input logic [31:0] exp, input string tag);
        @(negedge clk);
        sw_sel = sel;
        q_exp.push_back(exp);
        q_tag.push_back(tag);
        @(posedge clk);
        #2;
    endtask

    task automatic wr(input logic [1:0] sel, input logic [5:0] d);
        @(negedge clk);
        sw_wr = 1'b1; sw_sel = sel; sw_wdata = d;
        @(posedge clk);
        #1;
        sw_wr = 1'b0;
    endtask

    // k = {parity, timeout, external, protect}
    task automatic xfer(input int m, input bit lk, input logic [31:0] a, input logic [3:0] k,
                        input bit st, input logic [1:0] er, input bit eb, input string tag,
                        input bit w = 1'b0, input logic [5:0] wd = '0);
        @(negedge clk);
        xfer_done = 1'b1; xfer_master = 1'(m); xfer_lock = lk; xfer_addr = a;
        {ev_parity, ev_timeout, ev_ext, ev_protect} = k;
        xfer_start = st;
        sw_wr = w; sw_sel = 2'(m); sw_wdata = wd;
        #1;
        check(err_resp === er, {tag, " R5 err_resp"}, 32'(err_resp), 32'(er));
        check(bus_start === eb, {tag, " R4 bus_start"}, 32'(bus_start), 32'(eb));
        @(posedge clk);
        #1;
        xfer_done = 1'b0; xfer_lock = 1'b0; xfer_start = 1'b0; sw_wr = 1'b0;
        {ev_parity, ev_timeout, ev_ext, ev_protect} = '0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        rd(2'd0, 32'h0, "R1 status0");
        rd(2'd1, 32'h0, "R1 status1");
        rd(2'd2, 32'h0, "R1 address");
        rd(2'd3, 32'h0, "R1 config");

        // R3: disabled timeout and parity
        xfer(0, 1'b0, 32'h1111_0000, 4'b0100, 1'b0, 2'b00, 1'b0, "R3 timeout off");
        xfer(1, 1'b1, 32'h1111_0004, 4'b1000, 1'b0, 2'b00, 1'b0, "R3 parity off");
        rd(2'd0, 32'h0, "R3 status0 untouched");
        rd(2'd1, 32'h0, "R3 status1 untouched");
        rd(2'd2, 32'h0, "R3 address untouched");

        // R2 R6 R10: unlocked errors overwrite
        xfer(0, 1'b0, 32'hA000_0001, 4'b0010, 1'b1, 2'b01, 1'b1, "R2 external");
        rd(2'd0, 32'h02, "R2 status0 external");
        rd(2'd2, 32'hA000_0001, "R10 address A1");
        xfer(0, 1'b0, 32'hA000_0002, 4'b0001, 1'b1, 2'b01, 1'b0, "R4 protect");
        rd(2'd0, 32'h01, "R6 status0 overwritten");
        rd(2'd2, 32'hA000_0002, "R10 address A2");
        xfer(1, 1'b0, 32'h0, 4'b0000, 1'b1, 2'b00, 1'b1, "R4 clean start");

        // R3: enable both
        wr(2'd3, 6'h03);
        rd(2'd3, 32'h3, "R3 config readback");

        // R7 R8: m1 locking timeout
        xfer(1, 1'b1, 32'hA000_0003, 4'b0100, 1'b0, 2'b10, 1'b0, "R8 m1 lock");
        rd(2'd1, 32'h34, "R8 status1 locked");
        rd(2'd2, 32'hA000_0003, "R8 address captured");
        xfer(1, 1'b1, 32'hA000_0004, 4'b1000, 1'b0, 2'b10, 1'b0, "R7 m1 again");
        rd(2'd1, 32'h34, "R7 status1 frozen");
        rd(2'd2, 32'hA000_0003, "R9 address frozen");
        xfer(0, 1'b1, 32'hA000_0005, 4'b0010, 1'b0, 2'b01, 1'b0, "R8 m0 lock");
        rd(2'd0, 32'h12, "R8 status0 no address lock");
        xfer(0, 1'b0, 32'hA000_0006, 4'b0001, 1'b0, 2'b01, 1'b0, "R7 m0 again");
        rd(2'd0, 32'h12, "R7 status0 frozen");
        rd(2'd2, 32'hA000_0003, "R9 address still frozen");

        // R11: clear m1, address released
        wr(2'd1, 6'h3F);
        rd(2'd1, 32'h0, "R11 status1 cleared");
        rd(2'd2, 32'hA000_0003, "R11 address kept");
        xfer(0, 1'b0, 32'hA000_0007, 4'b0010, 1'b0, 2'b01, 1'b0, "R10 m0 unlocked addr");
        rd(2'd0, 32'h12, "R7 status0 still frozen");
        rd(2'd2, 32'hA000_0007, "R10 address updated");

        // R12: clear wins
        xfer(0, 1'b1, 32'hA000_0008, 4'b0010, 1'b0, 2'b01, 1'b0, "R12 collide", 1'b1, 6'h3F);
        rd(2'd0, 32'h0, "R12 status0 cleared");
        rd(2'd2, 32'hA000_0007, "R12 address not logged");

        xfer(0, 1'b1, 32'hA000_0009, 4'b1000, 1'b0, 2'b01, 1'b0, "R8 m0 parity lock");
        rd(2'd0, 32'h38, "R8 status0 both locks");
        rd(2'd2, 32'hA000_0009, "R8 address A9");
        xfer(1, 1'b1, 32'hA000_000A, 4'b0010, 1'b0, 2'b10, 1'b0, "R8 m1 denied");
        rd(2'd1, 32'h12, "R8 status1 field lock only");
        rd(2'd2, 32'hA000_0009, "R9 address A9 kept");

        // R11: partial clear of address lock only
        wr(2'd0, 6'h20);
        rd(2'd0, 32'h18, "R11 status0 partial clear");
        xfer(1, 1'b0, 32'hA000_000B, 4'b0010, 1'b0, 2'b10, 1'b0, "R10 m1 after release");
        rd(2'd1, 32'h12, "R7 status1 frozen");
        rd(2'd2, 32'hA000_000B, "R10 address A11");

        repeat (3) @(posedge clk);
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done_flag) begin
            done_flag = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule